// File: doc/BRIEF.md
# Power Request Retry Sequencer

This block is a small bus master that runs one complete power-state transaction for a single power area against a power controller's register port. A requester supplies a direction (power up or power down), the byte offset of the area's channel register group, the area's bit inside that group and the area's bit in the controller's shared interrupt status. It then pulses `start_i`. The sequencer performs the full register dialogue and returns a two-bit result with a one-cycle `done_o` pulse.

The dialogue has three polling loops, each with its own attempt limit. The first loop waits for the controller to be ready to accept a request. The second loop resubmits the request for as long as the channel reports a rejection, and each resubmission repeats the ready wait. The third loop waits for the area's completion flag. Polls are paced by a microsecond tick input. A lock input from the surrounding arbitration holds back the start of a transaction that has already been requested.

Top module: `pwr_seq`

## Requirements
- R1: A start pulse in idle latches all request inputs. While `lock_i` is high, no bus access is made, and the transaction begins once `lock_i` is low.
- R2: The first access of every transaction is a write of `1 << irq_bit_i` to `SYS_BASE + 0x08` (completion clear).
- R3: Readiness is read from `SYS_BASE + 0x00`. Bit 1 must be set for power-up and bit 0 for power-down, and the other bit does not count.
- R4: After `RDY_TRIES` (100) consecutive reads without the ready bit, the transaction ends with result 1 (busy). No request is submitted and no further access follows.
- R5: A submission writes `1 << chan_bit_i` to `chan_base_i + 0x0C` for power-up or to `chan_base_i + 0x04` for power-down.
- R6: Each submission is followed by a read of `chan_base_i + 0x14`. If bit `chan_bit_i` is set, the sequencer restarts the ready wait and then resubmits.
- R7: When `ERR_TRIES` (100) submissions have all been rejected, the result is 2 (I/O error) and no further access follows.
- R8: After acceptance, `SYS_BASE + 0x04` is read until bit `irq_bit_i` is set, for at most `CMPL_TRIES` (1000) reads. A timeout gives result 2.
- R9: The completion path always ends with a second clear write identical to the one in R2, and the result is 0 on success.
- R10: `done_o` is high for exactly one clock per transaction. `result_o` is valid with it: 0 ok, 1 busy, 2 I/O error.
- R11: At most one bus access is outstanding. `bus_req_o` and its address, direction and data stay stable until `bus_ack_i`, and `bus_req_o` drops on the clock after the acknowledge.
- R12: A failed poll, whether a ready, rejection or completion poll, is repeated only after a cycle with `tick_us_i` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_us_i | input | 1 | One-cycle microsecond pacing strobe |
| lock_i | input | 1 | Holds a requested transaction off while high |
| start_i | input | 1 | Starts a transaction when idle |
| power_on_i | input | 1 | 1 = power up, 0 = power down |
| chan_base_i | input | AW | Byte offset of the area's channel register group |
| chan_bit_i | input | $clog2(DW) | Area bit in the channel registers |
| irq_bit_i | input | $clog2(DW) | Area bit in the interrupt status registers |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 2 | 0 ok, 1 busy, 2 I/O error |
| bus_req_o | output | 1 | Register access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | AW | Register byte address |
| bus_wdata_o | output | DW | Write data |
| bus_ack_i | input | 1 | Access acknowledge; read data valid with it |
| bus_rdata_i | input | DW | Read data |

## Verification
The request rises on the clock after the sequencer enters an access state. The bench's register model acknowledges it half a cycle later and samples address and data at that point, so each access takes three clocks. `done_o` rises two clocks after the acknowledge of the final access. The bench therefore waits for it by sampling on falling edges with a bounded poll, and then checks on the next falling edge that the pulse has gone. The model counts each kind of access per transaction, so the attempt limits (100 ready reads, 100 submissions, 1000 completion reads), the 99-failure boundaries and the presence or absence of the closing clear are checked as exact counts. Hold-off by lock and by the tick is checked by counting accesses over a fixed window of cycles.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    RES_OK    = 2'd0,
    RES_BUSY  = 2'd1,
    RES_IOERR = 2'd2
  } res_e;

  // controller-wide registers (relative to SYS_BASE)
  localparam int unsigned OFS_READY = 32'h00;
  localparam int unsigned OFS_IRQ_ST = 32'h04;
  localparam int unsigned OFS_IRQ_CLR = 32'h08;
  // per-channel registers (relative to chan_base)
  localparam int unsigned OFS_CH_DOWN = 32'h04;
  localparam int unsigned OFS_CH_UP = 32'h0C;
  localparam int unsigned OFS_CH_REJ = 32'h14;
  // ready bit positions
  localparam int unsigned RDY_UP_BIT = 1;
  localparam int unsigned RDY_DOWN_BIT = 0;

  typedef enum logic [3:0] {
    S_IDLE,
    S_LOCKW,
    S_CLR_PRE,
    S_RDY_RD,
    S_RDY_WAIT,
    S_SUBMIT,
    S_REJ_RD,
    S_REJ_WAIT,
    S_CMPL_RD,
    S_CMPL_WAIT,
    S_CLR_POST,
    S_FIN
  } st_e;

endpackage

// File: rtl/pwr_seq_bus_port.sv
module pwr_seq_bus_port #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          rsp_o,
  output logic [DW-1:0] rdata_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_rdata_i
);

  logic          req_q, we_q, rsp_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      rsp_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      rsp_q <= 1'b0;
      if (!req_q && go_i) begin
        req_q   <= 1'b1;
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end else if (req_q && bus_ack_i) begin
        req_q   <= 1'b0;
        rsp_q   <= 1'b1;
        rdata_q <= bus_rdata_i;
      end
    end
  end

  assign bus_req_o   = req_q;
  assign bus_we_o    = we_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign rsp_o       = rsp_q;
  assign rdata_o     = rdata_q;

endmodule

// File: rtl/pwr_seq_try_cnt.sv
module pwr_seq_try_cnt #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + CW'(1);
  end

  // true when the attempt now being judged is the final one
  assign last_o = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int unsigned AW         = 16,
  parameter int unsigned DW         = 32,
  parameter int unsigned SYS_BASE   = 0,
  parameter int unsigned RDY_TRIES  = 100,
  parameter int unsigned ERR_TRIES  = 100,
  parameter int unsigned CMPL_TRIES = 1000,
  localparam int unsigned BW        = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_us_i,
  input  logic          lock_i,
  input  logic          start_i,
  input  logic          power_on_i,
  input  logic [AW-1:0] chan_base_i,
  input  logic [BW-1:0] chan_bit_i,
  input  logic [BW-1:0] irq_bit_i,
  output logic          done_o,
  output logic [1:0]    result_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_rdata_i
);

  localparam logic [AW-1:0] A_READY   = AW'(SYS_BASE + OFS_READY);
  localparam logic [AW-1:0] A_IRQ_ST  = AW'(SYS_BASE + OFS_IRQ_ST);
  localparam logic [AW-1:0] A_IRQ_CLR = AW'(SYS_BASE + OFS_IRQ_CLR);

  st_e           st_q, st_d;
  res_e          res_q, res_d;
  logic          on_q;
  logic [AW-1:0] base_q;
  logic [BW-1:0] chan_q, irq_q;
  logic          pend_q;

  logic          go, acc_we, rsp;
  logic [AW-1:0] acc_addr;
  logic [DW-1:0] acc_wdata, rdata;
  logic          is_access;
  logic          rdy_bit, rej_bit, cmpl_bit;
  logic          rdy_last, rej_last, cmpl_last;
  logic          rdy_clr, rdy_inc, rej_inc, cmpl_inc, run_clr;

  // request latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_q   <= 1'b0;
      base_q <= '0;
      chan_q <= '0;
      irq_q  <= '0;
    end else if (st_q == S_IDLE && start_i) begin
      on_q   <= power_on_i;
      base_q <= chan_base_i;
      chan_q <= chan_bit_i;
      irq_q  <= irq_bit_i;
    end
  end

  // access issue
  always_comb begin
    is_access = 1'b0;
    acc_we    = 1'b0;
    acc_addr  = '0;
    acc_wdata = '0;
    unique case (st_q)
      S_CLR_PRE, S_CLR_POST: begin
        is_access = 1'b1;
        acc_we    = 1'b1;
        acc_addr  = A_IRQ_CLR;
        acc_wdata = DW'(1) << irq_q;
      end
      S_RDY_RD: begin
        is_access = 1'b1;
        acc_addr  = A_READY;
      end
      S_SUBMIT: begin
        is_access = 1'b1;
        acc_we    = 1'b1;
        acc_addr  = base_q + (on_q ? AW'(OFS_CH_UP) : AW'(OFS_CH_DOWN));
        acc_wdata = DW'(1) << chan_q;
      end
      S_REJ_RD: begin
        is_access = 1'b1;
        acc_addr  = base_q + AW'(OFS_CH_REJ);
      end
      S_CMPL_RD: begin
        is_access = 1'b1;
        acc_addr  = A_IRQ_ST;
      end
      default: ;
    endcase
  end

  assign go = is_access && !pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  pend_q <= 1'b0;
    else if (go)  pend_q <= 1'b1;
    else if (rsp) pend_q <= 1'b0;
  end

  pwr_seq_bus_port #(.AW(AW), .DW(DW)) u_port (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (go),
    .we_i        (acc_we),
    .addr_i      (acc_addr),
    .wdata_i     (acc_wdata),
    .rsp_o       (rsp),
    .rdata_o     (rdata),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i),
    .bus_rdata_i (bus_rdata_i)
  );

  // response decode
  assign rdy_bit  = rdata[on_q ? RDY_UP_BIT : RDY_DOWN_BIT];
  assign rej_bit  = rdata[chan_q];
  assign cmpl_bit = rdata[irq_q];

  assign run_clr  = (st_q == S_CLR_PRE);
  assign rdy_clr  = run_clr || (st_q == S_REJ_WAIT);
  assign rdy_inc  = (st_q == S_RDY_RD) && rsp && !rdy_bit;
  assign rej_inc  = (st_q == S_REJ_RD) && rsp && rej_bit;
  assign cmpl_inc = (st_q == S_CMPL_RD) && rsp && !cmpl_bit;

  pwr_seq_try_cnt #(.LIMIT(RDY_TRIES)) u_rdy_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .clr_i (rdy_clr), .inc_i (rdy_inc), .last_o (rdy_last)
  );

  pwr_seq_try_cnt #(.LIMIT(ERR_TRIES)) u_rej_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .clr_i (run_clr), .inc_i (rej_inc), .last_o (rej_last)
  );

  pwr_seq_try_cnt #(.LIMIT(CMPL_TRIES)) u_cmpl_cnt (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .clr_i (run_clr), .inc_i (cmpl_inc), .last_o (cmpl_last)
  );

  // sequencing
  always_comb begin
    st_d  = st_q;
    res_d = res_q;
    unique case (st_q)
      S_IDLE:    if (start_i) st_d = S_LOCKW;
      S_LOCKW:   if (!lock_i) st_d = S_CLR_PRE;
      S_CLR_PRE: if (rsp) st_d = S_RDY_RD;
      S_RDY_RD: if (rsp) begin
        if (rdy_bit) st_d = S_SUBMIT;
        else if (rdy_last) begin
          st_d  = S_FIN;
          res_d = RES_BUSY;
        end else st_d = S_RDY_WAIT;
      end
      S_RDY_WAIT: if (tick_us_i) st_d = S_RDY_RD;
      S_SUBMIT:   if (rsp) st_d = S_REJ_RD;
      S_REJ_RD: if (rsp) begin
        if (!rej_bit) st_d = S_CMPL_RD;
        else if (rej_last) begin
          st_d  = S_FIN;
          res_d = RES_IOERR;
        end else st_d = S_REJ_WAIT;
      end
      S_REJ_WAIT: if (tick_us_i) st_d = S_RDY_RD;
      S_CMPL_RD: if (rsp) begin
        if (cmpl_bit) begin
          st_d  = S_CLR_POST;
          res_d = RES_OK;
        end else if (cmpl_last) begin
          st_d  = S_CLR_POST;
          res_d = RES_IOERR;
        end else st_d = S_CMPL_WAIT;
      end
      S_CMPL_WAIT: if (tick_us_i) st_d = S_CMPL_RD;
      S_CLR_POST:  if (rsp) st_d = S_FIN;
      S_FIN:       st_d = S_IDLE;
      default:     st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      res_q <= RES_OK;
    end else begin
      st_q  <= st_d;
      res_q <= res_d;
    end
  end

  assign done_o   = (st_q == S_FIN);
  assign result_o = done_o ? res_q : 2'd0;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk
  import pwr_seq_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic [1:0]    result_o,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic          bus_ack_i,
  input st_e           st_i
);

  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o)
      && $stable(bus_we_o) && $stable(bus_wdata_o));

  p_req_drop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i |=> !bus_req_o);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_res_code_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> result_o != 2'd3);

  p_lock_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == S_LOCKW |-> !bus_req_o);

  p_wr_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_we_o |-> $countones(bus_wdata_o) == 1);

  p_idle_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_req_o);

endmodule

bind pwr_seq pwr_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_o      (done_o),
  .result_o    (result_o),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ack_i   (bus_ack_i),
  .st_i        (st_q)
);

// File: tb/pwr_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_tb_top;

  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic lock = 1'b0;
  logic start = 1'b0;
  logic pon = 1'b0;
  logic [AW-1:0] cbase = '0;
  logic [4:0] cbit = '0;
  logic [4:0] ibit = '0;
  logic done;
  logic [1:0] res;
  logic req, we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic ack = 1'b0;
  logic [DW-1:0] rdata = '0;

  always #2.5 clk = ~clk;

  pwr_seq dut_i (
    .clk_i (clk), .rst_ni (rst_n), .tick_us_i (tick), .lock_i (lock),
    .start_i (start), .power_on_i (pon), .chan_base_i (cbase),
    .chan_bit_i (cbit), .irq_bit_i (ibit), .done_o (done), .result_o (res),
    .bus_req_o (req), .bus_we_o (we), .bus_addr_o (addr),
    .bus_wdata_o (wdata), .bus_ack_i (ack), .bus_rdata_i (rdata)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // scenario knobs (-1 = never succeeds)
  int rdy_fail = 0;
  int rej_fail = 0;
  int cmpl_fail = 0;
  logic [DW-1:0] rdy_bits = 32'h3;

  // per-transaction observation, written only by the model
  int n_acc, n_clr, n_sub, n_sr, n_rej, n_isr, n_bad;
  int first_addr, last_addr;
  logic [DW-1:0] last_sub_data, last_clr_data;
  int last_sub_addr;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (start) begin
      n_acc = 0; n_clr = 0; n_sub = 0; n_sr = 0; n_rej = 0; n_isr = 0; n_bad = 0;
      first_addr = -1; last_addr = -1; last_sub_addr = -1;
      last_sub_data = '0; last_clr_data = '0;
    end
    if (ack) begin
      ack = 1'b0;
    end else if (req) begin
      ack = 1'b1;
      rdata = '0;
      if (n_acc == 0) first_addr = int'(addr);
      last_addr = int'(addr);
      n_acc++;
      if (we && addr == 16'h0008) begin
        n_clr++; last_clr_data = wdata;
      end else if (we && (addr == cbase + 16'h0C || addr == cbase + 16'h04)) begin
        n_sub++; last_sub_addr = int'(addr); last_sub_data = wdata;
      end else if (!we && addr == 16'h0000) begin
        rdata = (rdy_fail < 0 || n_sr < rdy_fail) ? 32'h0 : rdy_bits;
        n_sr++;
      end else if (!we && addr == cbase + 16'h14) begin
        // other channel bits always set to catch wrong bit selection
        rdata = (rej_fail < 0 || n_rej < rej_fail) ? 32'hFFFF_FFFF : ~(32'h1 << cbit);
        n_rej++;
      end else if (!we && addr == 16'h0004) begin
        rdata = (cmpl_fail < 0 || n_isr < cmpl_fail) ? ~(32'h1 << ibit) : (32'h1 << ibit);
        n_isr++;
      end else begin
        n_bad++;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic launch(input logic on, input int base, input int cb, input int ib);
    @(posedge clk); #1;
    pon = on; cbase = AW'(base); cbit = 5'(cb); ibit = 5'(ib);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag, output int r);
    int k;
    r = -1;
    for (k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (done) begin r = int'(res); break; end
    end
    chk({tag, " done seen"}, int'(k < 20000), 1);
    @(negedge clk);
    chk({tag, " R10 done one cycle"}, int'(done), 0);
  endtask

  task automatic knobs(input int rf, input int ef, input int cf, input logic [DW-1:0] rb);
    rdy_fail = rf; rej_fail = ef; cmpl_fail = cf; rdy_bits = rb;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 reset done low", int'(done), 0);
    chk("R11 reset req low", int'(req), 0);
  endtask

  task automatic t_up_clean();
    int r;
    knobs(0, 0, 0, 32'h2);
    launch(1'b1, 32'h100, 5, 9);
    wait_done("up_clean", r);
    chk("R9 up_clean result ok", r, 0);
    chk("R2 first access is clear", first_addr, 32'h8);
    chk("R2 clear mask", int'(last_clr_data), 32'h1 << 9);
    chk("R5 up submit addr", last_sub_addr, 32'h10C);
    chk("R5 up submit data", int'(last_sub_data), 32'h1 << 5);
    chk("R9 two clears", n_clr, 2);
    chk("R9 last access is clear", last_addr, 32'h8);
    chk("R11 no stray access", n_bad, 0);
  endtask

  task automatic t_down_retries();
    int r;
    knobs(5, 3, 7, 32'h1);
    launch(1'b0, 32'h240, 17, 2);
    wait_done("down_retry", r);
    chk("R9 down_retry result ok", r, 0);
    chk("R5 down submit addr", last_sub_addr, 32'h244);
    chk("R6 resubmissions", n_sub, 4);
    chk("R6 ready reads per attempt", n_sr, 9);
    chk("R6 rejection reads", n_rej, 4);
    chk("R8 completion reads", n_isr, 8);
    chk("R9 two clears", n_clr, 2);
  endtask

  task automatic t_busy();
    int r;
    knobs(-1, 0, 0, 32'h3);
    launch(1'b1, 32'h100, 1, 3);
    wait_done("busy", r);
    chk("R4 busy result", r, 1);
    chk("R4 ready reads", n_sr, 100);
    chk("R4 no submit", n_sub, 0);
    chk("R4 single clear", n_clr, 1);
  endtask

  task automatic t_wrong_ready_bit();
    int r;
    knobs(0, 0, 0, 32'h1);
    launch(1'b1, 32'h100, 1, 3);
    wait_done("dir_bit", r);
    chk("R3 down-ready bit ignored for up", r, 1);
    chk("R3 no submit", n_sub, 0);
  endtask

  task automatic t_ready_edge();
    int r;
    knobs(99, 0, 0, 32'h1);
    launch(1'b0, 32'h100, 4, 4);
    wait_done("rdy_edge", r);
    chk("R4 99 misses still ok", r, 0);
    chk("R4 ready reads at edge", n_sr, 100);
  endtask

  task automatic t_reject_fail();
    int r;
    knobs(0, -1, 0, 32'h3);
    launch(1'b1, 32'h300, 31, 0);
    wait_done("rej_fail", r);
    chk("R7 io error result", r, 2);
    chk("R7 submissions", n_sub, 100);
    chk("R7 no closing clear", n_clr, 1);
    chk("R7 no completion poll", n_isr, 0);
  endtask

  task automatic t_reject_edge();
    int r;
    knobs(0, 99, 0, 32'h3);
    launch(1'b1, 32'h300, 0, 31);
    wait_done("rej_edge", r);
    chk("R6 99 rejections still ok", r, 0);
    chk("R6 submissions at edge", n_sub, 100);
  endtask

  task automatic t_cmpl_timeout();
    int r;
    knobs(0, 0, -1, 32'h3);
    launch(1'b0, 32'h100, 2, 12);
    wait_done("cmpl_to", r);
    chk("R8 timeout io error", r, 2);
    chk("R8 completion reads", n_isr, 1000);
    chk("R9 clear after timeout", n_clr, 2);
    chk("R9 last access is clear", last_addr, 32'h8);
  endtask

  task automatic t_lock();
    int r;
    knobs(0, 0, 0, 32'h3);
    lock = 1'b1;
    launch(1'b1, 32'h100, 6, 6);
    repeat (20) @(negedge clk);
    chk("R1 no access while locked", n_acc, 0);
    chk("R1 no done while locked", int'(done), 0);
    @(posedge clk); #1;
    lock = 1'b0;
    wait_done("lock", r);
    chk("R1 runs after release", r, 0);
  endtask

  task automatic t_tick();
    int r;
    knobs(1, 0, 0, 32'h3);
    @(posedge clk); #1;
    tick = 1'b0;
    launch(1'b1, 32'h100, 7, 8);
    repeat (30) @(negedge clk);
    chk("R12 no repoll without tick", n_sr, 1);
    @(posedge clk); #1;
    tick = 1'b1;
    @(posedge clk); #1;
    tick = 1'b0;
    repeat (12) @(negedge clk);
    chk("R12 repoll after tick", n_sr, 2);
    chk("R12 submitted after tick", n_sub, 1);
    @(posedge clk); #1;
    tick = 1'b1;
    wait_done("tick", r);
    chk("R12 tick run ok", r, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_up_clean();
    t_down_retries();
    t_busy();
    t_wrong_ready_bit();
    t_ready_edge();
    t_reject_fail();
    t_reject_edge();
    t_cmpl_timeout();
    t_lock();
    t_tick();
    finish_run();
  end

  initial begin
    wait (cyc >= 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    finish_run();
  end

endmodule